// File: doc/BRIEF.md
# Eight-Channel Driver Fault Supervisor

This block sits between the command register of an eight-channel low-side driver and the gate drive of its output transistors. It receives each channel's commanded on/off bit along with raw fault indications from the output stages. Overcurrent and open-load are reported per channel, and over-temperature is a single indication for the whole device. Every per-channel fault passes through a counting filter before it is recorded. A recorded fault sets that channel's bit in a sticky status register and pulls an active-low summary flag low. A longer-lived overcurrent trips the channel off, unless the keep-on input is high.

The serial front end supplies two strobes. A clear strobe, issued when a new command word is latched, empties the status register and the trip latches. A capture strobe, issued when a read-out begins, copies a report word into a holding register. In each bit of the report, a healthy channel returns its commanded bit and a faulted channel returns the inverse. An over-temperature indication and the global kill input both force every gate off, and they override the keep-on input. The kill input also empties all filters and registers.

Top module: `chan_fault_guard`

## Requirements
- R1: A fault (overcurrent or open-load) on channel i that stays high for FILT_CYC consecutive clock cycles sets bit i of the status register. `fault_n` reads 0 from the cycle after that onward.
- R2: A fault that drops before FILT_CYC consecutive cycles is ignored. Its filter restarts from zero, the status stays clear and `fault_n` stays 1.
- R3: A one-cycle `stat_clear` empties the status register, and `fault_n` returns to 1. A fault that is still qualified at that moment stays recorded and keeps `fault_n` at 0.
- R4: A one-cycle `stat_capture` loads `stat_word` with the commanded bits XOR the recorded fault bits. Bit i equals `cmd_bits[i]` for a healthy channel and its inverse for a faulted one. The word holds until the next capture.
- R5: An overcurrent held high for TRIP_CYC consecutive cycles turns that channel's gate off. The channel stays off until the overcurrent is gone and `stat_clear` or `kill_all` is applied.
- R6: While `oc_keep_on` is 1, a tripped channel's gate follows its command again. Lowering the input restores the shutoff.
- R7: `ot_raw` high forces all gates off on the next cycle, even with `oc_keep_on` high. Nothing is latched, and gates follow the command again once it drops.
- R8: `kill_all` high forces all gates off. It also clears the filter counters, the status register, the trip latches and `stat_word`, so `fault_n` returns to 1.
- R9: With no fault, thermal or kill active, `gate_en` equals `cmd_bits` one clock after it is applied. After reset, `gate_en` and `stat_word` are 0 and `fault_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| kill_all | input | 1 | Global off and clear, active high |
| cmd_bits | input | N_CH | Commanded on/off state per channel |
| oc_raw | input | N_CH | Raw overcurrent/short indication per channel |
| ol_raw | input | N_CH | Raw open-load indication per channel |
| ot_raw | input | 1 | Over-temperature indication |
| oc_keep_on | input | 1 | Overrides the overcurrent shutoff |
| stat_clear | input | 1 | One-cycle strobe that clears status and trips |
| stat_capture | input | 1 | One-cycle strobe that loads the report word |
| gate_en | output | N_CH | Final gate enable per channel |
| stat_word | output | N_CH | Captured report word |
| fault_n | output | 1 | Active-low summary fault flag |

## Verification
The filter is driven with open-load pulses one cycle shorter than the limit and exactly at the limit. This separates the ignore case from the record case at the boundary. A kill is also inserted in the middle of a fault, which shows whether the counter really restarts. Overcurrent is held to one cycle before and one cycle after the trip limit. This separates the early filter flag from the later gate shutoff. The keep-on, thermal and clear inputs are then toggled over a tripped channel to expose their priority order. Report words are captured for both healthy and faulted channels, so a missing inversion or a wrong bit position shows up in the result.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
    localparam int unsigned CH_DEFAULT = 8;

    function automatic int unsigned cnt_bits(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction
endpackage

// File: rtl/fsup_filt.sv
module fsup_filt #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic raw,
    output logic hit
);
    localparam int unsigned W = fsup_pkg::cnt_bits(LIMIT);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr || !raw) begin
            cnt_d = '0;
        end else if (cnt_q != LIM) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hit = (cnt_q == LIM);

    // R2: a dropped fault restarts the filter
    assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !raw |=> !hit);
    // R8: kill empties the filter
    assert_clr_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !hit);
endmodule

// File: rtl/fsup_bank.sv
module fsup_bank #(
    parameter int unsigned N_CH  = 8,
    parameter int unsigned LIMIT = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic [N_CH-1:0] raw,
    output logic [N_CH-1:0] hit
);
    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        fsup_filt #(.LIMIT(LIMIT)) i_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (clr),
            .raw  (raw[i]),
            .hit  (hit[i])
        );
    end
endmodule

// File: rtl/chan_fault_guard.sv
module chan_fault_guard #(
    parameter int unsigned N_CH     = fsup_pkg::CH_DEFAULT,
    parameter int unsigned FILT_CYC = 4,
    parameter int unsigned TRIP_CYC = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            kill_all,
    input  logic [N_CH-1:0] cmd_bits,
    input  logic [N_CH-1:0] oc_raw,
    input  logic [N_CH-1:0] ol_raw,
    input  logic            ot_raw,
    input  logic            oc_keep_on,
    input  logic            stat_clear,
    input  logic            stat_capture,
    output logic [N_CH-1:0] gate_en,
    output logic [N_CH-1:0] stat_word,
    output logic            fault_n
);
    typedef struct packed {
        logic [N_CH-1:0] gate;
        logic [N_CH-1:0] stat;
        logic [N_CH-1:0] trip;
        logic [N_CH-1:0] snap;
    } guard_t;

    guard_t st_d, st_q;

    logic [N_CH-1:0] flt_hit;
    logic [N_CH-1:0] oc_hit;

    fsup_bank #(.N_CH(N_CH), .LIMIT(FILT_CYC)) i_flt_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (kill_all),
        .raw  (oc_raw | ol_raw),
        .hit  (flt_hit)
    );

    fsup_bank #(.N_CH(N_CH), .LIMIT(TRIP_CYC)) i_trip_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (kill_all),
        .raw  (oc_raw),
        .hit  (oc_hit)
    );

    always_comb begin
        st_d = st_q;
        if (kill_all) begin
            st_d = '0;
        end else begin
            st_d.stat = (stat_clear ? '0 : st_q.stat) | flt_hit;
            st_d.trip = (stat_clear ? '0 : st_q.trip) | oc_hit;
            if (stat_capture) begin
                st_d.snap = cmd_bits ^ st_q.stat;
            end
            if (ot_raw) begin
                st_d.gate = '0;
            end else if (oc_keep_on) begin
                st_d.gate = cmd_bits;
            end else begin
                st_d.gate = cmd_bits & ~st_d.trip;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gate_en   = st_q.gate;
    assign stat_word = st_q.snap;
    assign fault_n   = ~(|st_q.stat);

    // R1: a qualified fault is recorded on the next edge
    assert_latch_fault_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!kill_all && (|flt_hit)) |=> ((st_q.stat & $past(flt_hit)) == $past(flt_hit)));
    // R3: clear with nothing qualified releases the flag
    assert_clear_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clear && (flt_hit == '0)) |=> fault_n);
    // R6: keep-on makes gates follow the command
    assert_keep_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_keep_on && !kill_all && !ot_raw) |=> (gate_en == $past(cmd_bits)));
    // R7: thermal forces every gate off
    assert_thermal_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ot_raw |=> (gate_en == '0));
    // R8: kill forces every gate off and releases the flag
    assert_kill_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        kill_all |=> ((gate_en == '0) && fault_n));
endmodule

// File: tb/test_chan_fault_guard.sv
module test_chan_fault_guard;
    localparam int N = 8;
    localparam int FILT = 4;
    localparam int TRIP = 12;

    typedef enum logic [1:0] {K_GATE, K_FLAG, K_WORD} kind_t;
    typedef struct {
        kind_t      kind;
        logic [7:0] exp;
        string      req;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic kill_all = 1'b0;
    logic [N-1:0] cmd_bits = '0;
    logic [N-1:0] oc_raw = '0;
    logic [N-1:0] ol_raw = '0;
    logic ot_raw = 1'b0;
    logic oc_keep_on = 1'b0;
    logic stat_clear = 1'b0;
    logic stat_capture = 1'b0;
    logic [N-1:0] gate_en;
    logic [N-1:0] stat_word;
    logic fault_n;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    item_t sb[$];

    always #10 clk = ~clk;

    chan_fault_guard #(.N_CH(N), .FILT_CYC(FILT), .TRIP_CYC(TRIP)) i_chan_fault_guard (
        .clk(clk), .rst_n(rst_n), .kill_all(kill_all), .cmd_bits(cmd_bits),
        .oc_raw(oc_raw), .ol_raw(ol_raw), .ot_raw(ot_raw), .oc_keep_on(oc_keep_on),
        .stat_clear(stat_clear), .stat_capture(stat_capture),
        .gate_en(gate_en), .stat_word(stat_word), .fault_n(fault_n)
    );

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic expect_val(input kind_t k, input logic [7:0] v, input string r);
        item_t it;
        it.kind = k;
        it.exp  = v;
        it.req  = r;
        sb.push_back(it);
    endtask

    // monitor: compare queued expectations at the falling edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [7:0] got;
            it = sb.pop_front();
            case (it.kind)
                K_GATE:  got = gate_en;
                K_FLAG:  got = {7'd0, fault_n};
                default: got = stat_word;
            endcase
            total++;
            if (got !== it.exp) begin
                bad++;
                $display("FAIL %s kind=%0d got=%h exp=%h", it.req, it.kind, got, it.exp);
            end
        end
    end

    task automatic pulse_clear();
        stat_clear = 1'b1; tick(1); stat_clear = 1'b0;
    endtask

    task automatic pulse_capture();
        stat_capture = 1'b1; tick(1); stat_capture = 1'b0;
    endtask

    initial begin
        tick(2);
        rst_n = 1'b1;
        tick(1);
        expect_val(K_GATE, 8'h00, "R9 reset gate");
        expect_val(K_FLAG, 8'h01, "R9 reset flag");
        expect_val(K_WORD, 8'h00, "R9 reset word");

        cmd_bits = 8'hA5; tick(1);
        expect_val(K_GATE, 8'hA5, "R9 gate follows cmd");

        // R2: glitch one cycle short of the limit
        ol_raw[2] = 1'b1; tick(FILT - 1); ol_raw[2] = 1'b0; tick(2);
        expect_val(K_FLAG, 8'h01, "R2 short glitch ignored");
        pulse_capture();
        expect_val(K_WORD, 8'hA5, "R2 healthy report");

        // R1: fault held exactly FILT cycles
        ol_raw[1] = 1'b1; tick(FILT); ol_raw[1] = 1'b0; tick(1);
        expect_val(K_FLAG, 8'h00, "R1 fault recorded");
        pulse_capture();
        expect_val(K_WORD, 8'hA7, "R4 faulted bit inverted");
        expect_val(K_GATE, 8'hA5, "R1 open-load leaves gate");

        // R3: clear releases flag
        pulse_clear();
        expect_val(K_FLAG, 8'h01, "R3 clear releases flag");
        pulse_capture();
        expect_val(K_WORD, 8'hA5, "R4 report after clear");

        // R3: persisting fault survives clear
        ol_raw[6] = 1'b1; tick(FILT + 2);
        pulse_clear();
        expect_val(K_FLAG, 8'h00, "R3 persisting fault stays");
        ol_raw[6] = 1'b0; tick(2);
        pulse_clear();
        expect_val(K_FLAG, 8'h01, "R3 clear after release");

        // R5: overcurrent trip at boundary
        oc_raw[0] = 1'b1; tick(TRIP);
        expect_val(K_GATE, 8'hA5, "R5 gate on before trip");
        expect_val(K_FLAG, 8'h00, "R1 overcurrent recorded");
        tick(1);
        expect_val(K_GATE, 8'hA4, "R5 gate tripped");

        // R6: keep-on override
        oc_keep_on = 1'b1; tick(1);
        expect_val(K_GATE, 8'hA5, "R6 keep-on restores gate");
        oc_keep_on = 1'b0; tick(1);
        expect_val(K_GATE, 8'hA4, "R6 shutoff back");

        oc_raw[0] = 1'b0; tick(2);
        expect_val(K_GATE, 8'hA4, "R5 trip latched after release");
        pulse_clear();
        expect_val(K_GATE, 8'hA5, "R5 clear releases trip");
        expect_val(K_FLAG, 8'h01, "R3 flag after trip clear");

        // R7: thermal
        ot_raw = 1'b1; tick(1);
        expect_val(K_GATE, 8'h00, "R7 thermal off");
        ot_raw = 1'b0; tick(1);
        expect_val(K_GATE, 8'hA5, "R7 thermal not latched");
        ot_raw = 1'b1; oc_keep_on = 1'b1; tick(1);
        expect_val(K_GATE, 8'h00, "R7 thermal over keep-on");
        ot_raw = 1'b0; oc_keep_on = 1'b0; tick(1);

        // R8: kill clears status, snapshot and gates
        ol_raw[4] = 1'b1; tick(FILT); ol_raw[4] = 1'b0; tick(1);
        pulse_capture();
        expect_val(K_WORD, 8'hB5, "R4 bit 4 inverted");
        kill_all = 1'b1; tick(1);
        expect_val(K_GATE, 8'h00, "R8 kill gates off");
        expect_val(K_FLAG, 8'h01, "R8 kill clears status");
        expect_val(K_WORD, 8'h00, "R8 kill clears word");
        kill_all = 1'b0; tick(1);
        expect_val(K_GATE, 8'hA5, "R8 gates back after kill");

        // R8: kill restarts a running filter
        ol_raw[3] = 1'b1; tick(2);
        kill_all = 1'b1; tick(1); kill_all = 1'b0;
        tick(2); ol_raw[3] = 1'b0; tick(2);
        expect_val(K_FLAG, 8'h01, "R8 kill restarted filter");

        cmd_bits = 8'h3C; tick(1);
        expect_val(K_GATE, 8'h3C, "R9 new command");
        tick(2);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule